// File: doc/BRIEF.md
# Queue-Driven Attack/Decay Frequency Governor

This block sets the operating frequency of one clock domain from how busy that domain is. At a fixed interval it samples the occupancy of the domain's input issue queue and compares it with the occupancy seen one interval earlier. If the queue has filled noticeably, it raises the frequency target sharply, by about 6%. If the queue has not filled, it lowers the target very slightly, by about 0.2%. A small rise below the threshold leaves the target as it is.

The target is kept internally as an unsigned fixed-point value in MHz with 8 fractional bits. It is confined to the 250–1000 MHz band. It is turned into an operating-point index from 0 to 319, which a separate voltage/clock sequencer reads. The index is registered and changes only once per interval.

Top module: `freq_governor`

## Requirements
- R1: While reset is asserted and right after it is released, `op_index` is 319, because the internal target starts at 1000 MHz.
- R2: A decision is made once every `STEP_CYCLES` clock cycles, counted from reset release. `op_index` changes only in the cycle after an interval boundary. The value of `q_level` is used only at that boundary; its value at any other time has no effect.
- R3: The growth threshold is ceil(2·`q_cap`/100) entries, with a minimum of 1. For example, capacity 200 gives 4, capacity 150 gives 3, and capacities 50 and 0 both give 1.
- R4: Attack applies when the new sample exceeds the previous one by at least the threshold. The target becomes floor(target·1085/1024), limited to at most 1000 MHz (fixed-point 256000).
- R5: Decay applies when the new sample is equal to or lower than the previous one. The target becomes floor(target·1022/1024), limited to at least 250 MHz (fixed-point 64000).
- R6: When the sample rises by at least 1 but by less than the threshold, the target is unchanged.
- R7: At the first boundary after reset there is no earlier sample to compare against. That boundary applies decay and stores the sample as the previous level.
- R8: `op_index` equals floor((T − 64000)/600), saturated to 319, where T is the fixed-point target (MHz × 256) after the decision. Each index step is therefore 2.34375 MHz.
- R9: The target never leaves the 64000..256000 fixed-point band, so `op_index` stays within 0..319.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_level | input | QW | Current issue-queue occupancy |
| q_cap | input | QW | Issue-queue capacity in entries |
| op_index | output | $clog2(POINTS) | Target operating-point index, 0..319 |

## Verification
A wrong saved previous level or a wrong primed flag does not show up at once. It appears one boundary late, as an attack where a hold or decay was expected, and that produces an index jump of several steps. A wrong fixed-point target shows up only as the index drifts over many boundaries. For that reason, long decay runs to the floor and long attack runs to the ceiling are compared against a model after every interval. A wrong interval counter appears as an index change at a point other than the boundary, or no change at the boundary, within the first interval.

// File: rtl/fgov_pkg.sv
package fgov_pkg;
    typedef enum logic [1:0] {
        MV_HOLD   = 2'd0,
        MV_ATTACK = 2'd1,
        MV_DECAY  = 2'd2
    } move_e;
endpackage

// File: rtl/fgov_step_timer.sv
module fgov_step_timer #(
    parameter int STEP_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(STEP_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == CW'(STEP_CYCLES - 1));
        s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fgov_occ_judge.sv
module fgov_occ_judge
    import fgov_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [QW-1:0] level,
    input  logic [QW-1:0] cap,
    output move_e         move
);
    localparam int TW = QW + 8;

    typedef struct packed {
        logic [QW-1:0] prev;
        logic          primed;
    } jdg_t;

    jdg_t s_d, s_q;
    logic [TW-1:0] thr;
    logic [TW-1:0] growth;

    always_comb begin
        s_d    = s_q;
        thr    = ((TW'(cap) << 1) + TW'(99)) / TW'(100);
        if (thr == '0) thr = TW'(1);
        growth = TW'(level) - TW'(s_q.prev);
        if (!s_q.primed || level <= s_q.prev) move = MV_DECAY;
        else if (growth >= thr)               move = MV_ATTACK;
        else                                  move = MV_HOLD;
        if (tick) begin
            s_d.prev   = level;
            s_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fgov_scaler.sv
module fgov_scaler
    import fgov_pkg::*;
#(
    parameter int FW      = 18,
    parameter int IW      = 9,
    parameter int FMIN_FX = 64000,
    parameter int FMAX_FX = 256000,
    parameter int STEP_FX = 600,
    parameter int POINTS  = 320,
    parameter int ATK_NUM = 1085,
    parameter int DCY_NUM = 1022,
    parameter int SHIFT   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  move_e         move,
    output logic [FW-1:0] target,
    output logic [IW-1:0] index
);
    localparam int PW = FW + 12;

    typedef struct packed {
        logic [FW-1:0] target;
        logic [IW-1:0] index;
    } scl_t;

    scl_t s_d, s_q;
    logic [PW-1:0] atk_p, dcy_p;
    logic [FW-1:0] atk_v, dcy_v, nxt, diff, quo;

    always_comb begin
        s_d   = s_q;
        atk_p = (PW'(s_q.target) * PW'(ATK_NUM)) >> SHIFT;
        dcy_p = (PW'(s_q.target) * PW'(DCY_NUM)) >> SHIFT;
        atk_v = (atk_p > PW'(FMAX_FX)) ? FW'(FMAX_FX) : atk_p[FW-1:0];
        dcy_v = (dcy_p < PW'(FMIN_FX)) ? FW'(FMIN_FX) : dcy_p[FW-1:0];
        case (move)
            MV_ATTACK: nxt = atk_v;
            MV_DECAY:  nxt = dcy_v;
            default:   nxt = s_q.target;
        endcase
        diff = nxt - FW'(FMIN_FX);
        quo  = diff / FW'(STEP_FX);
        if (tick) begin
            s_d.target = nxt;
            s_d.index  = (quo > FW'(POINTS - 1)) ? IW'(POINTS - 1) : quo[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.target <= FW'(FMAX_FX);
            s_q.index  <= IW'(POINTS - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign target = s_q.target;
    assign index  = s_q.index;
endmodule

// File: rtl/freq_governor.sv
module freq_governor
    import fgov_pkg::*;
#(
    parameter int STEP_CYCLES = 50000,
    parameter int QW          = 8,
    parameter int FMIN_MHZ    = 250,
    parameter int FMAX_MHZ    = 1000,
    parameter int POINTS      = 320,
    parameter int FRAC        = 8,
    parameter int ATK_NUM     = 1085,
    parameter int DCY_NUM     = 1022,
    parameter int SHIFT       = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [QW-1:0]             q_level,
    input  logic [QW-1:0]             q_cap,
    output logic [$clog2(POINTS)-1:0] op_index
);
    localparam int FMIN_FX = FMIN_MHZ << FRAC;
    localparam int FMAX_FX = FMAX_MHZ << FRAC;
    localparam int STEP_FX = (FMAX_FX - FMIN_FX) / POINTS;
    localparam int FW      = $clog2(FMAX_FX + 1);
    localparam int IW      = $clog2(POINTS);

    logic          step_tick;
    move_e         move;
    logic [FW-1:0] target;

    fgov_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (step_tick)
    );

    fgov_occ_judge #(.QW(QW)) u_jdg (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (step_tick),
        .level(q_level),
        .cap  (q_cap),
        .move (move)
    );

    fgov_scaler #(
        .FW(FW), .IW(IW), .FMIN_FX(FMIN_FX), .FMAX_FX(FMAX_FX),
        .STEP_FX(STEP_FX), .POINTS(POINTS), .ATK_NUM(ATK_NUM),
        .DCY_NUM(DCY_NUM), .SHIFT(SHIFT)
    ) u_scl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (step_tick),
        .move  (move),
        .target(target),
        .index (op_index)
    );
endmodule

// File: rtl/fgov_chk.sv
module fgov_chk
    import fgov_pkg::*;
#(
    parameter int FW      = 18,
    parameter int IW      = 9,
    parameter int FMIN_FX = 64000,
    parameter int FMAX_FX = 256000,
    parameter int POINTS  = 320
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_tick,
    input move_e         move,
    input logic [FW-1:0] target,
    input logic [IW-1:0] op_index
);
    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_index <= IW'(POINTS - 1));

    // R9
    tgt_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target >= FW'(FMIN_FX) && target <= FW'(FMAX_FX));

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(op_index));

    // R4
    attack_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && move == MV_ATTACK |=> target >= $past(target));

    // R5
    decay_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && move == MV_DECAY |=> target <= $past(target));

    // R6
    hold_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && move == MV_HOLD |=> $stable(target));
endmodule

bind freq_governor fgov_chk #(
    .FW(FW), .IW(IW), .FMIN_FX(FMIN_FX), .FMAX_FX(FMAX_FX), .POINTS(POINTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_tick(step_tick),
    .move     (move),
    .target   (target),
    .op_index (op_index)
);

// File: tb/sim_freq_governor.sv
module sim_freq_governor;
    localparam int STEP = 16;
    localparam int QW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] q_level = '0;
    logic [QW-1:0] q_cap = '0;
    logic [8:0]    op_index;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];
    int last_exp = 319;
    bit done = 1'b0;

    int m_tgt = 256000;
    int m_prev = 0;
    bit m_primed = 1'b0;

    freq_governor #(.STEP_CYCLES(STEP), .QW(QW)) u0 (
        .clk(clk), .rst_n(rst_n), .q_level(q_level), .q_cap(q_cap), .op_index(op_index)
    );

    always #5ns clk = ~clk;

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: op_index=%0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_step(input int lvl, input int cap);
        int thr;
        int t;
        thr = (2 * cap + 99) / 100;
        if (thr == 0) thr = 1;
        t = m_tgt;
        if (!m_primed || lvl <= m_prev) begin
            t = (t * 1022) >>> 10;
            if (t < 64000) t = 64000;
        end else if (lvl - m_prev >= thr) begin
            t = (t * 1085) >>> 10;
            if (t > 256000) t = 256000;
        end
        m_tgt = t;
        m_prev = lvl;
        m_primed = 1'b1;
        t = (t - 64000) / 600;
        return (t > 319) ? 319 : t;
    endfunction

    // Driver: holds one level across one interval and queues the expected index.
    task automatic step(input int lvl, input int cap, input string tag, input bit glitch);
        #3ns;
        q_level = QW'(lvl);
        q_cap   = QW'(cap);
        exp_q.push_back(model_step(lvl, cap));
        tag_q.push_back(tag);
        if (glitch) begin
            repeat (STEP / 2) @(posedge clk);
            #3ns q_level = QW'(200);
            repeat (2) @(posedge clk);
            #3ns q_level = QW'(lvl);
            repeat (STEP - STEP / 2 - 2) @(posedge clk);
        end else begin
            repeat (STEP) @(posedge clk);
        end
    endtask

    // Monitor: mid-interval stability, then compare at each boundary.
    initial begin
        @(posedge rst_n);
        forever begin
            repeat (STEP / 2) @(posedge clk);
            #1ns check(int'(op_index), last_exp, "R2 mid-interval");
            repeat (STEP - STEP / 2) @(posedge clk);
            #1ns;
            if (exp_q.size() > 0) begin
                last_exp = exp_q.pop_front();
                check(int'(op_index), last_exp, tag_q.pop_front());
            end
        end
    end

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: done=%0d expected 1", done);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1ns check(int'(op_index), 319, "R1 in reset");
        #2ns rst_n = 1'b1;
        #1ns check(int'(op_index), 319, "R1 after release");
        // cap 200: threshold 4
        step(10, 200, "R7 first boundary decays", 1'b0);
        step(10, 200, "R5 equal level decays", 1'b0);
        step(14, 200, "R4 attack saturates at top", 1'b0);
        step(17, 200, "R6 sub-threshold hold, R2 glitch ignored", 1'b1);
        step(5, 200, "R5 drop decays", 1'b0);
        for (int i = 0; i < 760; i++) step(5, 200, "R8 decay run", 1'b0);
        step(5, 200, "R5 R9 floor", 1'b0);
        step(9, 200, "R3 R4 attack at exact threshold 4", 1'b0);
        // cap 50: threshold 1
        for (int i = 0; i < 30; i++) step(10 + i, 50, "R4 R8 attack run", 1'b0);
        step(40, 50, "R4 R9 ceiling", 1'b0);
        for (int i = 0; i < 40; i++) step(40, 50, "R5 decay", 1'b0);
        step(41, 0, "R3 zero cap threshold 1", 1'b0);
        step(43, 150, "R3 R6 cap 150 growth 2 holds", 1'b0);
        step(46, 150, "R3 R4 cap 150 growth 3 attacks", 1'b0);
        step(47, 49, "R3 cap 49 threshold 1", 1'b0);
        repeat (STEP + 2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule